// File: doc/BRIEF.md
# Mezzanine Slot Power Sequencer

This block controls power for a mezzanine card slot. A three-position DIP switch sets the regulator voltage code for the slot's adjustable rail. A switch in the ON position reads as 0, so the three raw switch inputs form the code directly, with bit 2 as the most significant bit. When all three switches are OFF (raw value 111), the host takes over: the code comes from host GPIO lines 2..0, and host GPIO line 3 decides whether slot power is wanted. With any other switch setting, power is always wanted.

When power is wanted, the code is usable and a card is seated, the block brings the rails up in a fixed order:

1. +12 V.
2. The adjustable rail, together with its pre-driver supply. The block then waits for the adjustable rail's power-ok, with a timeout.
3. +3.3 V.
4. Power-good to the card.

The block drops power-good first when it has to power down. It then takes the rails down in reverse order, with a settle interval between steps. A power-ok timeout shuts everything off and holds a fault until the request is withdrawn. The voltage code is latched at the start of each sequence. A code change while powered forces a complete power-down and a fresh sequence with the new code.

Code meanings are: 000 = 3.3 V, 001 = 2.5 V, 010 = 1.8 V, 011 = 1.5 V, 100 = 1.25 V, 101 = 1.2 V, 110 = 0.8 V. The FPGA bank on the slot cannot run at 0.8 V, so code 110 is refused. All inputs are taken as already synchronous to `clk`.

Top module: `fmc_pwr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `en_p12v`, `en_vadj`, `en_p3v3`, `predrv_en`, `pg_c2m` and `fault` are 0.
- R2: When `sw_vid` is not 111, the live code equals `sw_vid`, and power is requested whatever the value of `host_gpio[3]`. While no rail is enabled, `vadj_code` follows the live code one cycle later.
- R3: When `sw_vid` is 111, the live code equals `host_gpio[2:0]`, and power is requested only while `host_gpio[3]` is 1.
- R4: A live code of 110 never starts a sequence; `en_p12v` stays 0.
- R5: No sequence starts while `card_present_n` is 1.
- R6: Power-up runs in a fixed order with this timing:
  - `en_p12v` rises 1 cycle after power is requested with a card present and a usable code.
  - `en_vadj` rises SETTLE_CYCLES+1 cycles after `en_p12v`.
  - `en_p3v3` rises 1 cycle after `vadj_pok` is first sampled high while only the adjustable rail is waiting.
  - `pg_c2m` rises SETTLE_CYCLES+1 cycles after `en_p3v3`.
- R7: `predrv_sel` is 1 exactly when `vadj_code` is 000, and `predrv_en` equals `en_vadj`.
- R8: If `vadj_pok` has not been seen high within POK_TIMEOUT_CYCLES+1 cycles after `en_vadj` rises, `fault` rises and all three rail enables are 0 in that same cycle.
- R9: While `fault` is 1 and power remains requested, no rail is enabled, even if `vadj_pok` goes high. `fault` falls 1 cycle after the request is removed, and a later request sequences normally.
- R10: With power-good high, any of the following drops `pg_c2m` 1 cycle later while `en_p3v3` is still 1: the request is removed, the card is removed, or `vadj_pok` falls. The rails then fall in this order, each SETTLE_CYCLES+1 cycles after the previous step: `en_p3v3`, then `en_vadj`, then `en_p12v`.
- R11: If the live code changes while rails are up, `vadj_code` keeps its latched value while `en_vadj` is high and the block powers down completely. It then re-sequences and presents the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_vid | input | 3 | Raw DIP switch levels (ON = 0), bit 2 most significant |
| host_gpio | input | 4 | Host lines: [2:0] software voltage code, [3] software power request |
| card_present_n | input | 1 | Card seated, active low |
| vadj_pok | input | 1 | Adjustable rail power-ok |
| en_p12v | output | 1 | +12 V rail enable |
| en_vadj | output | 1 | Adjustable rail enable |
| en_p3v3 | output | 1 | +3.3 V rail enable |
| vadj_code | output | 3 | Voltage code to the adjustable regulator |
| predrv_sel | output | 1 | Pre-driver supply select, 1 for the 3.3 V code |
| predrv_en | output | 1 | Pre-driver supply enable |
| pg_c2m | output | 1 | Carrier-to-mezzanine power-good |
| fault | output | 1 | Sticky power-ok timeout fault |

## Verification
The hardest situation to reach from the ports is the sticky fault. Reaching it needs a completed power-down after a power-ok loss, then an automatic restart, and then the adjustable rail timing out while the request stays present. The stimulus gets there by dropping `vadj_pok` while power-good is high and keeping it low through the restart. It then raises `vadj_pok` again during the fault to show the block stays off, and clears the fault only by withdrawing the software request in host mode. The second hard case is a live code change while powered, which must hold the latched code through the entire reverse sequence. The stimulus drives it by changing `host_gpio[2:0]` with power-good high.

// File: rtl/fmc_pwr_pkg.sv
package fmc_pwr_pkg;

    localparam int CODE_W = 3;

    typedef logic [CODE_W-1:0] vcode_t;

    localparam vcode_t CODE_HOST  = 3'b111;
    localparam vcode_t CODE_UNSUP = 3'b110;
    localparam vcode_t CODE_HIGHV = 3'b000;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_UP12,
        ST_UPADJ,
        ST_UP33,
        ST_ON,
        ST_DNPG,
        ST_DN33,
        ST_DNADJ,
        ST_DN12,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        vcode_t     code;
    } seq_reg_t;

endpackage

// File: rtl/fmc_vsel_src.sv
module fmc_vsel_src
    import fmc_pwr_pkg::*;
(
    input  logic [CODE_W-1:0] sw_vid,
    input  logic [3:0]        host_gpio,
    output logic [CODE_W-1:0] live_code_o,
    output logic              pwr_req_o,
    output logic              code_ok_o
);

    logic host_mode;

    always_comb begin
        host_mode = (sw_vid == CODE_HOST);
        if (host_mode) begin
            live_code_o = host_gpio[CODE_W-1:0];
            pwr_req_o   = host_gpio[3];
        end else begin
            live_code_o = sw_vid;
            pwr_req_o   = 1'b1;
        end
        code_ok_o = (live_code_o != CODE_UNSUP);
    end

endmodule

// File: rtl/fmc_seq_timer.sv
module fmc_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // A freshly loaded non-zero count must not be reported as expired.
    p_no_early_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_i) && ($past(load_val_i) != '0)) |-> !expired_o);

endmodule

// File: rtl/fmc_pwr_fsm.sv
module fmc_pwr_fsm
    import fmc_pwr_pkg::*;
#(
    parameter int TMR_W              = 8,
    parameter int SETTLE_CYCLES      = 16,
    parameter int POK_TIMEOUT_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] live_code_i,
    input  logic              pwr_req_i,
    input  logic              code_ok_i,
    input  logic              card_present_n,
    input  logic              vadj_pok,
    input  logic              tmr_expired_i,
    output logic              tmr_load_o,
    output logic [TMR_W-1:0]  tmr_val_o,
    output logic              en_p12v_o,
    output logic              en_vadj_o,
    output logic              en_p3v3_o,
    output logic              pg_o,
    output logic              fault_o,
    output logic [CODE_W-1:0] code_o
);

    localparam logic [TMR_W-1:0] SETTLE_VAL  = TMR_W'(SETTLE_CYCLES);
    localparam logic [TMR_W-1:0] TIMEOUT_VAL = TMR_W'(POK_TIMEOUT_CYCLES);

    seq_reg_t cur_q, nxt_d;
    logic     go;
    logic     code_chg;

    always_comb begin
        nxt_d      = cur_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = SETTLE_VAL;
        go         = pwr_req_i && code_ok_i && !card_present_n;
        code_chg   = (live_code_i != cur_q.code);

        case (cur_q.state)
            ST_OFF: begin
                nxt_d.code = live_code_i;
                if (go) begin
                    nxt_d.state = ST_UP12;
                    tmr_load_o  = 1'b1;
                end
            end
            ST_UP12: begin
                if (!go || code_chg) begin
                    nxt_d.state = ST_DN12;
                    tmr_load_o  = 1'b1;
                end else if (tmr_expired_i) begin
                    nxt_d.state = ST_UPADJ;
                    tmr_load_o  = 1'b1;
                    tmr_val_o   = TIMEOUT_VAL;
                end
            end
            ST_UPADJ: begin
                if (!go || code_chg) begin
                    nxt_d.state = ST_DNADJ;
                    tmr_load_o  = 1'b1;
                end else if (vadj_pok) begin
                    nxt_d.state = ST_UP33;
                    tmr_load_o  = 1'b1;
                end else if (tmr_expired_i) begin
                    nxt_d.state = ST_FAULT;
                end
            end
            ST_UP33: begin
                if (!go || code_chg || !vadj_pok) begin
                    nxt_d.state = ST_DN33;
                    tmr_load_o  = 1'b1;
                end else if (tmr_expired_i) begin
                    nxt_d.state = ST_ON;
                end
            end
            ST_ON: begin
                if (!go || code_chg || !vadj_pok) begin
                    nxt_d.state = ST_DNPG;
                    tmr_load_o  = 1'b1;
                end
            end
            ST_DNPG: begin
                if (tmr_expired_i) begin
                    nxt_d.state = ST_DN33;
                    tmr_load_o  = 1'b1;
                end
            end
            ST_DN33: begin
                if (tmr_expired_i) begin
                    nxt_d.state = ST_DNADJ;
                    tmr_load_o  = 1'b1;
                end
            end
            ST_DNADJ: begin
                if (tmr_expired_i) begin
                    nxt_d.state = ST_DN12;
                    tmr_load_o  = 1'b1;
                end
            end
            ST_DN12: begin
                if (tmr_expired_i) begin
                    nxt_d.state = ST_OFF;
                end
            end
            ST_FAULT: begin
                if (!pwr_req_i) begin
                    nxt_d.state = ST_OFF;
                end
            end
            default: begin
                nxt_d.state = ST_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_OFF, code: CODE_HIGHV};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        en_p12v_o = cur_q.state inside {ST_UP12, ST_UPADJ, ST_UP33, ST_ON,
                                        ST_DNPG, ST_DN33, ST_DNADJ};
        en_vadj_o = cur_q.state inside {ST_UPADJ, ST_UP33, ST_ON, ST_DNPG, ST_DN33};
        en_p3v3_o = cur_q.state inside {ST_UP33, ST_ON, ST_DNPG};
        pg_o      = (cur_q.state == ST_ON);
        fault_o   = (cur_q.state == ST_FAULT);
        code_o    = cur_q.code;
    end

    p_adj_after_12v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_vadj_o) |-> $past(en_p12v_o));

    p_33_after_pok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_p3v3_o) |-> $past(vadj_pok));

    p_pg_drops_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_p3v3_o) |-> !$past(pg_o));

    p_fault_rails_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!en_p12v_o && !en_vadj_o && !en_p3v3_o && !pg_o));

    p_code_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vadj_o && $past(en_vadj_o)) |-> $stable(code_o));

endmodule

// File: rtl/fmc_pwr_seq.sv
module fmc_pwr_seq
    import fmc_pwr_pkg::*;
#(
    parameter int SETTLE_CYCLES      = 125000,
    parameter int POK_TIMEOUT_CYCLES = 1250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sw_vid,
    input  logic [3:0] host_gpio,
    input  logic       card_present_n,
    input  logic       vadj_pok,
    output logic       en_p12v,
    output logic       en_vadj,
    output logic       en_p3v3,
    output logic [2:0] vadj_code,
    output logic       predrv_sel,
    output logic       predrv_en,
    output logic       pg_c2m,
    output logic       fault
);

    localparam int TMR_MAX = (SETTLE_CYCLES > POK_TIMEOUT_CYCLES) ?
                             SETTLE_CYCLES : POK_TIMEOUT_CYCLES;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    logic [CODE_W-1:0] live_code;
    logic              pwr_req;
    logic              code_ok;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_expired;

    fmc_vsel_src i_src (
        .sw_vid      (sw_vid),
        .host_gpio   (host_gpio),
        .live_code_o (live_code),
        .pwr_req_o   (pwr_req),
        .code_ok_o   (code_ok)
    );

    fmc_seq_timer #(
        .W (TMR_W)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    fmc_pwr_fsm #(
        .TMR_W              (TMR_W),
        .SETTLE_CYCLES      (SETTLE_CYCLES),
        .POK_TIMEOUT_CYCLES (POK_TIMEOUT_CYCLES)
    ) i_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .live_code_i    (live_code),
        .pwr_req_i      (pwr_req),
        .code_ok_i      (code_ok),
        .card_present_n (card_present_n),
        .vadj_pok       (vadj_pok),
        .tmr_expired_i  (tmr_expired),
        .tmr_load_o     (tmr_load),
        .tmr_val_o      (tmr_val),
        .en_p12v_o      (en_p12v),
        .en_vadj_o      (en_vadj),
        .en_p3v3_o      (en_p3v3),
        .pg_o           (pg_c2m),
        .fault_o        (fault),
        .code_o         (vadj_code)
    );

    assign predrv_sel = (vadj_code == CODE_HIGHV);
    assign predrv_en  = en_vadj;

    p_start_needs_card_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_p12v) |-> !$past(card_present_n));

    p_never_start_unsup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_p12v) |-> ($past(live_code) != CODE_UNSUP));

endmodule

// File: tb/test_fmc_pwr_seq.sv
module test_fmc_pwr_seq;

    localparam int S = 6;
    localparam int T = 20;

    localparam int SIG_EN12 = 0;
    localparam int SIG_ADJ  = 1;
    localparam int SIG_33   = 2;
    localparam int SIG_PG   = 3;
    localparam int SIG_FLT  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sw_vid = 3'b000;
    logic [3:0] host_gpio = 4'b0000;
    logic       card_present_n = 1'b1;
    logic       vadj_pok = 1'b0;
    logic       en_p12v, en_vadj, en_p3v3, predrv_sel, predrv_en, pg_c2m, fault;
    logic [2:0] vadj_code;

    int checks = 0;
    int errors = 0;
    int n;

    always #4 clk = ~clk;

    fmc_pwr_seq #(
        .SETTLE_CYCLES      (S),
        .POK_TIMEOUT_CYCLES (T)
    ) i_fmc_pwr_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .sw_vid         (sw_vid),
        .host_gpio      (host_gpio),
        .card_present_n (card_present_n),
        .vadj_pok       (vadj_pok),
        .en_p12v        (en_p12v),
        .en_vadj        (en_vadj),
        .en_p3v3        (en_p3v3),
        .vadj_code      (vadj_code),
        .predrv_sel     (predrv_sel),
        .predrv_en      (predrv_en),
        .pg_c2m         (pg_c2m),
        .fault          (fault)
    );

    // vector fields: [10:8] switches, [7:4] host gpio, [3:1] expected code, [0] expected pre-driver select
    localparam logic [10:0] VECS [0:9] = '{
        {3'b000, 4'b0000, 3'b000, 1'b1},
        {3'b001, 4'b1111, 3'b001, 1'b0},
        {3'b010, 4'b0000, 3'b010, 1'b0},
        {3'b011, 4'b1000, 3'b011, 1'b0},
        {3'b100, 4'b0111, 3'b100, 1'b0},
        {3'b101, 4'b0110, 3'b101, 1'b0},
        {3'b110, 4'b0001, 3'b110, 1'b0},
        {3'b111, 4'b0000, 3'b000, 1'b1},
        {3'b111, 4'b1011, 3'b011, 1'b0},
        {3'b111, 4'b0101, 3'b101, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic sig(input int s);
        case (s)
            SIG_EN12: return en_p12v;
            SIG_ADJ:  return en_vadj;
            SIG_33:   return en_p3v3;
            SIG_PG:   return pg_c2m;
            default:  return fault;
        endcase
    endfunction

    task automatic wait_for(input int s, input logic val, input int limit, output int cnt);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (sig(s) != val && cnt < limit);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 en_p12v in reset", int'(en_p12v), 0);
        chk("R1 pg_c2m in reset", int'(pg_c2m), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rails after reset", int'({en_p12v, en_vadj, en_p3v3, predrv_en}), 0);
        chk("R1 pg and fault after reset", int'({pg_c2m, fault}), 0);

        // source selection table, no card seated
        for (int i = 0; i < 10; i++) begin
            sw_vid    = VECS[i][10:8];
            host_gpio = VECS[i][7:4];
            repeat (2) @(negedge clk);
            if (VECS[i][10:8] == 3'b111) begin
                chk("R3 host code", int'(vadj_code), int'(VECS[i][3:1]));
            end else begin
                chk("R2 switch code", int'(vadj_code), int'(VECS[i][3:1]));
            end
            chk("R7 predrv_sel", int'(predrv_sel), int'(VECS[i][0]));
            chk("R5 no start without card", int'(en_p12v), 0);
        end

        // R6 / R7: full power-up with the 3.3 V code
        sw_vid = 3'b000; host_gpio = 4'b0000; vadj_pok = 1'b0;
        @(negedge clk);
        card_present_n = 1'b0;
        wait_for(SIG_EN12, 1'b1, 20, n);   chk("R6 en_p12v delay", n, 1);
        wait_for(SIG_ADJ, 1'b1, 40, n);    chk("R6 en_vadj delay", n, S + 1);
        chk("R7 predrv_sel for 000", int'(predrv_sel), 1);
        chk("R7 predrv_en follows", int'(predrv_en), 1);
        chk("R6 en_p3v3 waits pok", int'(en_p3v3), 0);
        repeat (3) @(negedge clk);
        chk("R6 en_p3v3 still waits pok", int'(en_p3v3), 0);
        vadj_pok = 1'b1;
        wait_for(SIG_33, 1'b1, 20, n);     chk("R6 en_p3v3 after pok", n, 1);
        wait_for(SIG_PG, 1'b1, 40, n);     chk("R6 pg delay", n, S + 1);

        // R10: card removal, reverse order
        card_present_n = 1'b1;
        wait_for(SIG_PG, 1'b0, 20, n);     chk("R10 pg drops first", n, 1);
        chk("R10 en_p3v3 held while pg drops", int'(en_p3v3), 1);
        wait_for(SIG_33, 1'b0, 40, n);     chk("R10 en_p3v3 off delay", n, S + 1);
        chk("R10 en_vadj held", int'(en_vadj), 1);
        wait_for(SIG_ADJ, 1'b0, 40, n);    chk("R10 en_vadj off delay", n, S + 1);
        chk("R7 predrv_en off with rail", int'(predrv_en), 0);
        chk("R10 en_p12v held", int'(en_p12v), 1);
        wait_for(SIG_EN12, 1'b0, 40, n);   chk("R10 en_p12v off delay", n, S + 1);
        repeat (10) @(negedge clk);

        // R10: power-ok loss while on, switch code 001, R2 request ignores gpio3
        sw_vid = 3'b001; host_gpio = 4'b0000; card_present_n = 1'b0;
        wait_for(SIG_PG, 1'b1, 60, n);     chk("R2 switch mode powers up", int'(pg_c2m), 1);
        chk("R7 predrv_sel for 001", int'(predrv_sel), 0);
        vadj_pok = 1'b0;
        wait_for(SIG_PG, 1'b0, 20, n);     chk("R10 pg drops on pok loss", n, 1);
        wait_for(SIG_EN12, 1'b0, 60, n);   chk("R10 all rails down", int'({en_p12v, en_vadj, en_p3v3}), 0);
        vadj_pok = 1'b1;
        card_present_n = 1'b1;
        repeat (10) @(negedge clk);

        // R4: unsupported code
        sw_vid = 3'b110; card_present_n = 1'b0;
        repeat (30) @(negedge clk);
        chk("R4 code 110 blocked", int'(en_p12v), 0);

        // R3: host mode request bit
        sw_vid = 3'b111; host_gpio = 4'b0001;
        repeat (30) @(negedge clk);
        chk("R3 no request without gpio3", int'(en_p12v), 0);
        host_gpio = 4'b1001;
        wait_for(SIG_EN12, 1'b1, 20, n);   chk("R3 gpio3 starts sequence", n, 1);
        wait_for(SIG_PG, 1'b1, 60, n);     chk("R3 host mode powered", int'(pg_c2m), 1);
        chk("R3 host code latched", int'(vadj_code), 1);

        // R11: code change while powered
        host_gpio = 4'b1010;
        wait_for(SIG_PG, 1'b0, 20, n);     chk("R11 pg drops on code change", n, 1);
        chk("R11 code held while powered", int'(vadj_code), 1);
        wait_for(SIG_ADJ, 1'b0, 40, n);
        chk("R11 code held to rail off", int'(vadj_code), 1);
        wait_for(SIG_EN12, 1'b0, 40, n);   chk("R11 full power-down", int'(en_p12v), 0);
        wait_for(SIG_EN12, 1'b1, 40, n);   chk("R11 re-sequence starts", int'(en_p12v), 1);
        wait_for(SIG_ADJ, 1'b1, 40, n);    chk("R11 new code presented", int'(vadj_code), 2);
        wait_for(SIG_PG, 1'b1, 60, n);     chk("R11 re-sequence completes", int'(pg_c2m), 1);

        // R8: power-ok timeout after an automatic restart
        vadj_pok = 1'b0;
        wait_for(SIG_EN12, 1'b0, 60, n);
        wait_for(SIG_EN12, 1'b1, 40, n);   chk("R8 restart after pok loss", int'(en_p12v), 1);
        wait_for(SIG_ADJ, 1'b1, 40, n);
        wait_for(SIG_FLT, 1'b1, 60, n);    chk("R8 timeout delay", n, T + 1);
        chk("R8 rails off in fault", int'({en_p12v, en_vadj, en_p3v3, pg_c2m}), 0);

        // R9: sticky fault
        repeat (10) @(negedge clk);
        chk("R9 fault sticky", int'(fault), 1);
        vadj_pok = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 pok ignored in fault", int'({en_p12v, en_vadj, fault}), 1);
        host_gpio = 4'b0010;
        wait_for(SIG_FLT, 1'b0, 20, n);    chk("R9 fault clears on request removal", n, 1);
        host_gpio = 4'b1010;
        wait_for(SIG_EN12, 1'b1, 20, n);   chk("R9 restart after clear", n, 1);
        wait_for(SIG_PG, 1'b1, 60, n);     chk("R9 powered after clear", int'(pg_c2m), 1);

        finish_run();
    end

endmodule